// File: doc/BRIEF.md
# Split-Response Target Read Controller

This block is the target-side sequencer for reads that reach a device on a bus running in split-transaction mode. For every memory or I/O read it picks one of two paths. The first returns the data in the normal way when the register file can supply it within a 16-cycle window. The second answers at once with a split response, fetches the data in the background and later offers it to the bus as a split completion. The choice comes from two inputs. One is an expected-latency estimate. The other is a per-address "slow" flag, which forces the split path whatever the estimate says.

One completion slot records the pending split read: the requester ID, tag, address and byte count, and the data once it arrives. While that slot is full, every new read gets a retry. The slot stays full through the cycle that follows the bus's acceptance of the completion. A read also gets a retry while an immediate read is still waiting on the register file. Posted writes and incoming split completions are acknowledged in every state. The bus signalling itself and the register contents are outside the block.

States: `ST_IDLE` (free), `ST_FAST_WAIT` (immediate read waiting for data), `ST_SPLIT_FETCH` (split read waiting for data), `ST_CPL_OFFER` (completion presented to the bus) and `ST_CPL_FREE` (the cycle after acceptance). Transitions:
- IDLE→FAST_WAIT on a fast read.
- IDLE→SPLIT_FETCH on a slow read.
- FAST_WAIT→IDLE on register data.
- SPLIT_FETCH→CPL_OFFER on register data.
- CPL_OFFER→CPL_FREE on acceptance.
- CPL_FREE→IDLE unconditionally.

Top module: `split_read_target`

## Requirements
- R1: While reset is held and in the first cycle after it, every response pulse, `rf_rd_req`, `imm_valid` and `cpl_valid` are low.
- R2: A read in ST_IDLE, with `slow_hit`=0 and `lat_est` at most 16, gets `rsp_immediate` in the next cycle. In that same cycle `rf_rd_req` is high and `rf_rd_addr` holds the request address. Request kinds: `req_kind` 0 = memory read, 1 = I/O read, 2 = posted write, 3 = incoming split completion.
- R3: During ST_FAST_WAIT, `rf_rd_valid` produces `imm_valid` together with `imm_data` equal to `rf_rd_data` one cycle later. The block then returns to ST_IDLE.
- R4: A read in ST_IDLE with `lat_est` greater than 16 gets `rsp_split` in the next cycle and a register-file fetch at its address in that same cycle.
- R5: A read in ST_IDLE with `slow_hit`=1 gets `rsp_split`, even with `lat_est`=0.
- R6: One cycle after the register data for a split read arrives, `cpl_valid` rises. The completion carries that data and the read's requester ID, tag, address and byte count. These stay constant until a cycle with `cpl_accept` high.
- R7: A read gets `rsp_retry` in the next cycle when it arrives in any of these states: ST_SPLIT_FETCH, ST_CPL_OFFER, or the cycle right after `cpl_accept` (ST_CPL_FREE). A read one cycle later is served again.
- R8: A read that arrives during ST_FAST_WAIT gets `rsp_retry` in the next cycle.
- R9: In every state, a posted write gets `rsp_wr_ack` and an incoming split completion gets `rsp_cpl_in_ack` in the next cycle. Neither changes a pending completion.
- R10: Each read gets exactly one of `rsp_immediate`, `rsp_split` or `rsp_retry`, one cycle later. A cycle with no read produces none of them.
- R11: Register data for an immediate read must arrive within 16 cycles of the fetch. Later arrival is a design error that is flagged in simulation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_kind | input | 2 | 0 mem read, 1 I/O read, 2 posted write, 3 split completion in |
| req_addr | input | ADDR_W | Register address |
| req_rid | input | RID_W | Requester ID |
| req_tag | input | TAG_W | Transaction tag |
| req_bytes | input | BC_W | Byte count |
| lat_est | input | LAT_W | Expected read latency in cycles |
| slow_hit | input | 1 | Address is marked slow, forcing the split path |
| rsp_immediate | output | 1 | Read will be answered directly |
| rsp_split | output | 1 | Split response issued |
| rsp_retry | output | 1 | Read retried |
| rsp_wr_ack | output | 1 | Posted write accepted |
| rsp_cpl_in_ack | output | 1 | Incoming split completion accepted |
| rf_rd_req | output | 1 | Register-file fetch strobe |
| rf_rd_addr | output | ADDR_W | Register-file fetch address |
| rf_rd_valid | input | 1 | Register-file data ready |
| rf_rd_data | input | DATA_W | Register-file data |
| imm_valid | output | 1 | Immediate read data valid |
| imm_data | output | DATA_W | Immediate read data |
| cpl_valid | output | 1 | Split completion offered |
| cpl_rid | output | RID_W | Completion requester ID |
| cpl_tag | output | TAG_W | Completion tag |
| cpl_addr | output | ADDR_W | Completion address |
| cpl_bytes | output | BC_W | Completion byte count |
| cpl_data | output | DATA_W | Completion data |
| cpl_accept | input | 1 | Bus takes the completion this cycle |

## Verification
Each request's decision pulse (immediate, split, retry, write or completion acknowledge) is due exactly one cycle after the request. Immediate data and the rise of `cpl_valid` are due one cycle after `rf_rd_valid`. The driver stamps every expected item with that due cycle. The monitor compares each observed pulse with the head of its queue, matching both the value and the cycle. The completion is checked in the cycle the bench raises `cpl_accept`, against the cycle in which it first appeared. Reads are placed on both sides of the split-entry boundary (latency 16 and 17) and on both sides of the freed slot (the cycle after acceptance and the one after that).

// File: rtl/split_rd_pkg.sv
package split_rd_pkg;

    typedef enum logic [1:0] {
        K_MEM_RD  = 2'd0,
        K_IO_RD   = 2'd1,
        K_POST_WR = 2'd2,
        K_CPL_IN  = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_FAST_WAIT   = 3'd1,
        ST_SPLIT_FETCH = 3'd2,
        ST_CPL_OFFER   = 3'd3,
        ST_CPL_FREE    = 3'd4
    } ctl_state_e;

endpackage

// File: rtl/split_rd_decide.sv
module split_rd_decide #(
    parameter int LAT_W      = 6,
    parameter int FAST_LIMIT = 16
) (
    input  logic [LAT_W-1:0] lat_est,
    input  logic             slow_hit,
    output logic             take_split
);
    localparam logic [LAT_W:0] LIMIT_V = (LAT_W+1)'(FAST_LIMIT);

    // Slow attribute wins; otherwise anything beyond the window goes split.
    always_comb begin
        take_split = slow_hit || ({1'b0, lat_est} > LIMIT_V);
    end
endmodule

// File: rtl/split_rd_slot.sv
module split_rd_slot #(
    parameter int RID_W  = 16,
    parameter int TAG_W  = 5,
    parameter int ADDR_W = 12,
    parameter int BC_W   = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_load,
    input  logic [RID_W-1:0]  in_rid,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [BC_W-1:0]   in_bytes,
    input  logic              data_load,
    input  logic [DATA_W-1:0] in_data,
    output logic [RID_W-1:0]  q_rid,
    output logic [TAG_W-1:0]  q_tag,
    output logic [ADDR_W-1:0] q_addr,
    output logic [BC_W-1:0]   q_bytes,
    output logic [DATA_W-1:0] q_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_rid   <= '0;
            q_tag   <= '0;
            q_addr  <= '0;
            q_bytes <= '0;
        end else if (hdr_load) begin
            q_rid   <= in_rid;
            q_tag   <= in_tag;
            q_addr  <= in_addr;
            q_bytes <= in_bytes;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_data <= '0;
        end else if (data_load) begin
            q_data <= in_data;
        end
    end
endmodule

// File: rtl/split_rd_window.sv
module split_rd_window #(
    parameter int FAST_LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic done
);
    localparam int CNT_W = $clog2(FAST_LIMIT + 1) + 1;

    logic [CNT_W-1:0] wait_cnt;

    // Counts cycles spent waiting on an immediate read without data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (!active || done) begin
            wait_cnt <= '0;
        end else begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    a_r11_fast_window: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (wait_cnt < CNT_W'(FAST_LIMIT)))
        else $error("R11: immediate read data missed its window");
endmodule

// File: rtl/split_read_target.sv
module split_read_target
    import split_rd_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int RID_W      = 16,
    parameter int TAG_W      = 5,
    parameter int BC_W       = 12,
    parameter int LAT_W      = 6,
    parameter int FAST_LIMIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [RID_W-1:0]  req_rid,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [BC_W-1:0]   req_bytes,
    input  logic [LAT_W-1:0]  lat_est,
    input  logic              slow_hit,
    output logic              rsp_immediate,
    output logic              rsp_split,
    output logic              rsp_retry,
    output logic              rsp_wr_ack,
    output logic              rsp_cpl_in_ack,
    output logic              rf_rd_req,
    output logic [ADDR_W-1:0] rf_rd_addr,
    input  logic              rf_rd_valid,
    input  logic [DATA_W-1:0] rf_rd_data,
    output logic              imm_valid,
    output logic [DATA_W-1:0] imm_data,
    output logic              cpl_valid,
    output logic [RID_W-1:0]  cpl_rid,
    output logic [TAG_W-1:0]  cpl_tag,
    output logic [ADDR_W-1:0] cpl_addr,
    output logic [BC_W-1:0]   cpl_bytes,
    output logic [DATA_W-1:0] cpl_data,
    input  logic              cpl_accept
);
    ctl_state_e state_q, state_d;

    logic is_rd, is_wr, is_cin;
    logic take_split;
    logic n_imm, n_split, n_retry, n_fetch, n_immv;
    logic hdr_load, data_load;

    always_comb begin
        is_rd  = req_valid && ((req_kind == K_MEM_RD) || (req_kind == K_IO_RD));
        is_wr  = req_valid && (req_kind == K_POST_WR);
        is_cin = req_valid && (req_kind == K_CPL_IN);
    end

    split_rd_decide #(.LAT_W(LAT_W), .FAST_LIMIT(FAST_LIMIT)) decide_i (
        .lat_est    (lat_est),
        .slow_hit   (slow_hit),
        .take_split (take_split)
    );

    split_rd_slot #(
        .RID_W(RID_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .BC_W(BC_W), .DATA_W(DATA_W)
    ) slot_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_load  (hdr_load),
        .in_rid    (req_rid),
        .in_tag    (req_tag),
        .in_addr   (req_addr),
        .in_bytes  (req_bytes),
        .data_load (data_load),
        .in_data   (rf_rd_data),
        .q_rid     (cpl_rid),
        .q_tag     (cpl_tag),
        .q_addr    (cpl_addr),
        .q_bytes   (cpl_bytes),
        .q_data    (cpl_data)
    );

    split_rd_window #(.FAST_LIMIT(FAST_LIMIT)) window_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (state_q == ST_FAST_WAIT),
        .done   (rf_rd_valid)
    );

    // Next state and per-cycle decisions.
    always_comb begin
        state_d   = state_q;
        n_imm     = 1'b0;
        n_split   = 1'b0;
        n_retry   = 1'b0;
        n_fetch   = 1'b0;
        n_immv    = 1'b0;
        hdr_load  = 1'b0;
        data_load = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (is_rd) begin
                    n_fetch = 1'b1;
                    if (take_split) begin
                        n_split  = 1'b1;
                        hdr_load = 1'b1;
                        state_d  = ST_SPLIT_FETCH;
                    end else begin
                        n_imm   = 1'b1;
                        state_d = ST_FAST_WAIT;
                    end
                end
            end
            ST_FAST_WAIT: begin
                n_retry = is_rd;
                if (rf_rd_valid) begin
                    n_immv  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_SPLIT_FETCH: begin
                n_retry = is_rd;
                if (rf_rd_valid) begin
                    data_load = 1'b1;
                    state_d   = ST_CPL_OFFER;
                end
            end
            ST_CPL_OFFER: begin
                n_retry = is_rd;
                if (cpl_accept) begin
                    state_d = ST_CPL_FREE;
                end
            end
            ST_CPL_FREE: begin
                n_retry = is_rd;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_immediate  <= 1'b0;
            rsp_split      <= 1'b0;
            rsp_retry      <= 1'b0;
            rsp_wr_ack     <= 1'b0;
            rsp_cpl_in_ack <= 1'b0;
            rf_rd_req      <= 1'b0;
            rf_rd_addr     <= '0;
            imm_valid      <= 1'b0;
            imm_data       <= '0;
        end else begin
            rsp_immediate  <= n_imm;
            rsp_split      <= n_split;
            rsp_retry      <= n_retry;
            rsp_wr_ack     <= is_wr;
            rsp_cpl_in_ack <= is_cin;
            rf_rd_req      <= n_fetch;
            imm_valid      <= n_immv;
            if (n_fetch) begin
                rf_rd_addr <= req_addr;
            end
            if (n_immv) begin
                imm_data <= rf_rd_data;
            end
        end
    end

    always_comb begin
        cpl_valid = (state_q == ST_CPL_OFFER);
    end

    a_r10_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> ($countones({rsp_immediate, rsp_split, rsp_retry}) == 1))
        else $error("R10: read did not get exactly one answer");

    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rd |=> !(rsp_immediate || rsp_split || rsp_retry))
        else $error("R10: answer without a read");

    a_r5_slow_forces_split: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && is_rd && slow_hit) |=> rsp_split)
        else $error("R5: slow read not split");

    a_r7_retry_while_full: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SPLIT_FETCH || state_q == ST_CPL_OFFER || state_q == ST_CPL_FREE)
         && is_rd) |=> rsp_retry)
        else $error("R7: read not retried while slot full");

    a_r6_cpl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_accept) |=>
            (cpl_valid && $stable(cpl_tag) && $stable(cpl_rid) && $stable(cpl_data)))
        else $error("R6: completion dropped or changed before accept");

    a_r9_write_ack: assert property (@(posedge clk) disable iff (!rst_n)
        is_wr |=> rsp_wr_ack)
        else $error("R9: posted write not acknowledged");

    a_r9_cin_ack: assert property (@(posedge clk) disable iff (!rst_n)
        is_cin |=> rsp_cpl_in_ack)
        else $error("R9: incoming completion not acknowledged");

    a_r2_fetch_with_answer: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_immediate || rsp_split) |-> rf_rd_req)
        else $error("R2: answer without register fetch");
endmodule

// File: tb/split_read_target_tb_top.sv
`timescale 1ns/1ps
module split_read_target_tb_top;
    import split_rd_pkg::*;

    localparam int ADDR_W = 12, DATA_W = 32, RID_W = 16, TAG_W = 5, BC_W = 12, LAT_W = 6;
    localparam int EV_IMM = 0, EV_SPLIT = 1, EV_RETRY = 2, EV_WR = 3, EV_CIN = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n;
    logic              req_valid;
    logic [1:0]        req_kind;
    logic [ADDR_W-1:0] req_addr;
    logic [RID_W-1:0]  req_rid;
    logic [TAG_W-1:0]  req_tag;
    logic [BC_W-1:0]   req_bytes;
    logic [LAT_W-1:0]  lat_est;
    logic              slow_hit;
    logic rsp_immediate, rsp_split, rsp_retry, rsp_wr_ack, rsp_cpl_in_ack;
    logic              rf_rd_req;
    logic [ADDR_W-1:0] rf_rd_addr;
    logic              rf_rd_valid;
    logic [DATA_W-1:0] rf_rd_data;
    logic              imm_valid;
    logic [DATA_W-1:0] imm_data;
    logic              cpl_valid;
    logic [RID_W-1:0]  cpl_rid;
    logic [TAG_W-1:0]  cpl_tag;
    logic [ADDR_W-1:0] cpl_addr;
    logic [BC_W-1:0]   cpl_bytes;
    logic [DATA_W-1:0] cpl_data;
    logic              cpl_accept;

    split_read_target dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_rid(req_rid), .req_tag(req_tag), .req_bytes(req_bytes),
        .lat_est(lat_est), .slow_hit(slow_hit),
        .rsp_immediate(rsp_immediate), .rsp_split(rsp_split), .rsp_retry(rsp_retry),
        .rsp_wr_ack(rsp_wr_ack), .rsp_cpl_in_ack(rsp_cpl_in_ack),
        .rf_rd_req(rf_rd_req), .rf_rd_addr(rf_rd_addr), .rf_rd_valid(rf_rd_valid),
        .rf_rd_data(rf_rd_data), .imm_valid(imm_valid), .imm_data(imm_data),
        .cpl_valid(cpl_valid), .cpl_rid(cpl_rid), .cpl_tag(cpl_tag), .cpl_addr(cpl_addr),
        .cpl_bytes(cpl_bytes), .cpl_data(cpl_data), .cpl_accept(cpl_accept)
    );

    typedef struct { int due; int kind; logic [ADDR_W-1:0] addr; string req; } rsp_item_t;
    typedef struct { int due; logic [DATA_W-1:0] data; string req; } dat_item_t;
    typedef struct {
        int due; logic [RID_W-1:0] rid; logic [TAG_W-1:0] tag;
        logic [ADDR_W-1:0] addr; logic [BC_W-1:0] bytes; logic [DATA_W-1:0] data; string req;
    } cpl_item_t;

    rsp_item_t rsp_q[$];
    dat_item_t dat_q[$];
    cpl_item_t cpl_q[$];

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit running = 1'b0;
    bit finished = 1'b0;
    bit cpl_seen = 1'b0;
    int cpl_first = 0;

    logic [RID_W-1:0]  sp_rid;
    logic [TAG_W-1:0]  sp_tag;
    logic [ADDR_W-1:0] sp_addr;
    logic [BC_W-1:0]   sp_bytes;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_strobes();
        req_valid   = 1'b0;
        rf_rd_valid = 1'b0;
        cpl_accept  = 1'b0;
        slow_hit    = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            clear_strobes();
        end
    endtask

    task automatic send(input logic [1:0] kind, input logic [ADDR_W-1:0] addr,
                        input int lat, input bit slow, input logic [RID_W-1:0] rid,
                        input logic [TAG_W-1:0] tag, input logic [BC_W-1:0] bc,
                        input int expk, input string req);
        rsp_item_t it;
        @(negedge clk); #1;
        clear_strobes();
        req_valid = 1'b1;
        req_kind  = kind;
        req_addr  = addr;
        req_rid   = rid;
        req_tag   = tag;
        req_bytes = bc;
        lat_est   = LAT_W'(lat);
        slow_hit  = slow;
        it.due = cyc + 1; it.kind = expk; it.addr = addr; it.req = req;
        rsp_q.push_back(it);
        if (expk == EV_SPLIT) begin
            sp_rid = rid; sp_tag = tag; sp_addr = addr; sp_bytes = bc;
        end
    endtask

    task automatic rf_return(input logic [DATA_W-1:0] d, input bit to_cpl, input string req);
        @(negedge clk); #1;
        clear_strobes();
        rf_rd_valid = 1'b1;
        rf_rd_data  = d;
        if (to_cpl) begin
            cpl_item_t c;
            c.due = cyc + 1; c.rid = sp_rid; c.tag = sp_tag; c.addr = sp_addr;
            c.bytes = sp_bytes; c.data = d; c.req = req;
            cpl_q.push_back(c);
        end else begin
            dat_item_t di;
            di.due = cyc + 1; di.data = d; di.req = req;
            dat_q.push_back(di);
        end
    endtask

    task automatic accept(input string req);
        cpl_item_t c;
        @(negedge clk); #1;
        clear_strobes();
        cpl_accept = 1'b1;
        chk(cpl_valid == 1'b1, req, "cpl_valid at accept", longint'(cpl_valid), 1);
        if (cpl_q.size() == 0) begin
            chk(1'b0, req, "completion queue empty", 0, 1);
        end else begin
            c = cpl_q.pop_front();
            chk(cpl_first == c.due, c.req, "completion first cycle", cpl_first, c.due);
            chk(cpl_rid == c.rid && cpl_tag == c.tag, c.req, "completion rid/tag",
                longint'({cpl_rid, cpl_tag}), longint'({c.rid, c.tag}));
            chk(cpl_addr == c.addr && cpl_bytes == c.bytes, c.req, "completion addr/bytes",
                longint'({cpl_addr, cpl_bytes}), longint'({c.addr, c.bytes}));
            chk(cpl_data == c.data, c.req, "completion data", cpl_data, c.data);
        end
    endtask

    // Monitor: compares every produced result against the scoreboard.
    always @(negedge clk) begin
        if (running) begin
            int n;
            int k;
            n = int'(rsp_immediate) + int'(rsp_split) + int'(rsp_retry)
              + int'(rsp_wr_ack) + int'(rsp_cpl_in_ack);
            k = rsp_immediate ? EV_IMM : rsp_split ? EV_SPLIT : rsp_retry ? EV_RETRY :
                rsp_wr_ack ? EV_WR : EV_CIN;
            if (n > 1) chk(1'b0, "R10", "more than one response", n, 1);
            if (n >= 1) begin
                if (rsp_q.size() == 0) begin
                    chk(1'b0, "R10", "unexpected response", k, -1);
                end else begin
                    rsp_item_t it;
                    it = rsp_q.pop_front();
                    chk(k == it.kind, it.req, "response kind", k, it.kind);
                    chk(cyc == it.due, it.req, "response cycle", cyc, it.due);
                    if (it.kind == EV_IMM || it.kind == EV_SPLIT) begin
                        chk(rf_rd_req && rf_rd_addr == it.addr, it.req, "fetch address",
                            rf_rd_req ? longint'(rf_rd_addr) : -1, it.addr);
                    end
                end
            end
            if (imm_valid) begin
                if (dat_q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected imm_valid", imm_data, -1);
                end else begin
                    dat_item_t di;
                    di = dat_q.pop_front();
                    chk(imm_data == di.data, di.req, "immediate data", imm_data, di.data);
                    chk(cyc == di.due, di.req, "immediate data cycle", cyc, di.due);
                end
            end
            if (cpl_valid && !cpl_seen) begin
                cpl_seen  = 1'b1;
                cpl_first = cyc;
            end else if (!cpl_valid) begin
                cpl_seen = 1'b0;
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        clear_strobes();
        req_kind = '0; req_addr = '0; req_rid = '0; req_tag = '0; req_bytes = '0;
        lat_est = '0; rf_rd_data = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!(rsp_immediate || rsp_split || rsp_retry || rsp_wr_ack || rsp_cpl_in_ack),
            "R1", "responses in reset", 0, 0);
        chk(!(rf_rd_req || imm_valid || cpl_valid), "R1", "strobes in reset",
            longint'({rf_rd_req, imm_valid, cpl_valid}), 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!(rsp_immediate || rsp_split || rsp_retry || imm_valid || cpl_valid),
            "R1", "outputs after reset", 0, 0);
        running = 1'b1;

        // R2/R3: fast memory read, data after 2 cycles
        send(K_MEM_RD, 12'h010, 3, 1'b0, 16'h1111, 5'd1, 12'd4, EV_IMM, "R2");
        idle(2);
        rf_return(32'hA5A5_0001, 1'b0, "R3");
        idle(2);

        // R2 boundary: latency 16 still immediate; R11 data at window edge
        send(K_IO_RD, 12'h020, 16, 1'b0, 16'h2222, 5'd2, 12'd4, EV_IMM, "R2");
        // R8: read during immediate wait is retried; R9 write accepted
        send(K_MEM_RD, 12'h021, 1, 1'b0, 16'h2223, 5'd3, 12'd4, EV_RETRY, "R8");
        send(K_POST_WR, 12'h022, 0, 1'b0, 16'h2224, 5'd4, 12'd4, EV_WR, "R9");
        idle(12);
        rf_return(32'hDEAD_BEEF, 1'b0, "R11");
        idle(2);

        // R4: latency 17 goes split
        send(K_MEM_RD, 12'h155, 17, 1'b0, 16'hABCD, 5'd9, 12'd64, EV_SPLIT, "R4");
        send(K_MEM_RD, 12'h156, 0, 1'b0, 16'h0001, 5'd1, 12'd4, EV_RETRY, "R7");
        send(K_CPL_IN, 12'h000, 0, 1'b0, 16'h0002, 5'd2, 12'd4, EV_CIN, "R9");
        send(K_POST_WR, 12'h157, 0, 1'b0, 16'h0003, 5'd3, 12'd4, EV_WR, "R9");
        rf_return(32'h1234_5678, 1'b1, "R6");
        send(K_IO_RD, 12'h158, 0, 1'b0, 16'h0004, 5'd4, 12'd4, EV_RETRY, "R7");
        send(K_POST_WR, 12'h159, 0, 1'b0, 16'h0005, 5'd5, 12'd4, EV_WR, "R9");
        send(K_CPL_IN, 12'h15A, 0, 1'b0, 16'h0006, 5'd6, 12'd4, EV_CIN, "R9");
        idle(3);
        @(negedge clk);
        chk(cpl_valid && cpl_tag == 5'd9 && cpl_rid == 16'hABCD, "R6",
            "completion held before accept", longint'({cpl_valid, cpl_tag}), longint'({1'b1, 5'd9}));
        accept("R6");
        // R7: read in the cycle after accept still retried, next one served
        send(K_MEM_RD, 12'h160, 2, 1'b0, 16'h0007, 5'd7, 12'd4, EV_RETRY, "R7");
        send(K_MEM_RD, 12'h161, 2, 1'b0, 16'h0008, 5'd8, 12'd4, EV_IMM, "R7");
        rf_return(32'h0BAD_F00D, 1'b0, "R3");
        idle(2);

        // R5: slow attribute forces split even with zero latency
        send(K_IO_RD, 12'h3F0, 0, 1'b1, 16'h5A5A, 5'd31, 12'd8, EV_SPLIT, "R5");
        idle(4);
        rf_return(32'hCAFE_0005, 1'b1, "R5");
        accept("R5");
        idle(2);

        // R10/R9: writes and completions in idle give no read answers
        send(K_POST_WR, 12'h001, 30, 1'b1, 16'h0, 5'd0, 12'd0, EV_WR, "R10");
        send(K_CPL_IN, 12'h002, 30, 1'b1, 16'h0, 5'd0, 12'd0, EV_CIN, "R10");
        idle(2);
        // R2: ensure the state is still idle: fast read served
        send(K_MEM_RD, 12'h0FF, 16, 1'b0, 16'h0009, 5'd10, 12'd4, EV_IMM, "R2");
        rf_return(32'h7777_8888, 1'b0, "R3");
        idle(3);

        chk(rsp_q.size() == 0, "R10", "outstanding responses", rsp_q.size(), 0);
        chk(dat_q.size() == 0, "R3", "outstanding data", dat_q.size(), 0);
        chk(cpl_q.size() == 0, "R6", "outstanding completions", cpl_q.size(), 0);
        running = 1'b0;
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule